// File: doc/BRIEF.md
# Oversampling Serial Receive Engine

This block turns an asynchronous serial input into 8-bit characters. The line sits high when nothing is sent. A character begins with a low start bit. Eight data bits follow, least significant first, then an optional parity bit, then a high stop bit. The block does not divide a clock itself. It counts a single-cycle enable, supplied from outside, that pulses sixteen times per bit period. The raw line goes through a two-flop synchronizer before any logic samples it.

The engine first sees the line low on a tick. It then waits half a bit period, eight ticks, and looks again. If the line has gone back high, the event counts as noise and the engine returns to idle. If the start is confirmed, the engine samples every later bit sixteen ticks apart, close to the middle of each bit. When the stop bit samples high and the parity is correct, the engine presents the character with a one-cycle push strobe, meant to feed a receive FIFO. A stop bit that samples low gives a frame error pulse. A parity mismatch with a good stop bit gives a parity error pulse. After the stop sample the engine is idle at once, so the next start bit can follow straight away.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_push`, `rx_frame_err` and `rx_parity_err` are low, `rx_data` is 0, and a line that stays high produces no output.
- R2: With `par_en` low, a frame is start (0), 8 data bits with the LSB first, and stop (1). It produces one `rx_push` pulse, and `rx_data` holds the data bits with the first received bit at bit 0. `rx_data` changes only in a cycle where `rx_push` is high.
- R3: A low level seen on a tick but high again 8 ticks later is dropped as a glitch. It produces no push and no error, and the next valid frame is received correctly.
- R4: With `par_en` high, a parity bit follows the data. With `par_odd` low (even), the expected parity bit is the XOR of the 8 data bits. With `par_odd` high (odd), it is the inverse of that XOR. A matching parity bit with a high stop bit produces one push of the data.
- R5: With `par_en` high and a parity bit that does not match, a high stop bit produces one `rx_parity_err` pulse and no push.
- R6: A stop bit that samples low produces one `rx_frame_err` pulse, with no push and no parity error, whatever the parity bit was.
- R7: `rx_push`, `rx_frame_err` and `rx_parity_err` are each high for exactly one clock cycle per frame.
- R8: After the stop sample the engine returns to idle at once. A start bit that begins 12 ticks into the previous stop bit is received as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable, one pulse per 1/16 of a bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | Parity bit present when high |
| par_odd | input | 1 | Odd parity when high, even when low |
| rx_data | output | 8 | Last received character |
| rx_push | output | 1 | One-cycle strobe: `rx_data` holds a new character |
| rx_frame_err | output | 1 | One-cycle pulse: stop bit sampled low |
| rx_parity_err | output | 1 | One-cycle pulse: parity mismatch |

## Verification
The assertions check, on every cycle, four things. A push follows only a high synchronized line sample. A frame error follows only a low one. A push never comes together with an error. Every strobe lasts one cycle, and the data register changes only with a push. Other behaviours depend on whole sequences of bits and can only be shown by the bench scenarios. These include rejecting a short low pulse, LSB-first assembly of the byte, matching even and odd parity, and accepting a start bit that cuts the stop bit short. The bench drives these frames against bytes and expected outcomes that it computes itself.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4
   } rx_state_e;

   // Expected parity bit: even -> XOR of the data, odd -> its inverse
   function automatic logic expected_parity(input logic red_xor, input logic odd_sel);
      return red_xor ^ odd_sel;
   endfunction

endpackage

// File: rtl/serial_rx_sync.sv
`timescale 1ns/1ps
module serial_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serial_rx_sync: STAGES must be at least 2");
      end

      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RESET_VAL;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/serial_rx_timer.sv
`timescale 1ns/1ps
module serial_rx_timer #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clear,
   output logic half_hit,
   output logic full_hit
);

   localparam int CNT_W = $clog2(OVS);
   localparam int HALF  = OVS / 2;

   logic [CNT_W-1:0] cnt_q;

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("serial_rx_timer: OVS must be even and at least 4");
      end
   endgenerate

   assign half_hit = tick && (cnt_q == CNT_W'(HALF - 1));
   assign full_hit = tick && (cnt_q == CNT_W'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (full_hit) cnt_q <= '0;
         else          cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/serial_rx_fsm.sv
`timescale 1ns/1ps
module serial_rx_fsm
   import serial_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              half_hit,
   input  logic              full_hit,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              timer_clear,
   output logic [DATA_W-1:0] data_out,
   output logic              push,
   output logic              frame_err,
   output logic              parity_err
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   rx_state_e         state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shift_q;
   logic              par_bit_q;
   logic              cfg_en_q;
   logic              cfg_odd_q;
   logic              confirm;
   logic              par_bad;
   logic              par_en_eff;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_rx_fsm: DATA_W must be at least 2");
      end
      if (PAR_SUPPORT) begin : g_par_on
         assign par_en_eff = par_en;
      end else begin : g_par_off
         assign par_en_eff = 1'b0;
      end
   endgenerate

   assign confirm     = (state_q == RX_START) && half_hit && !line;
   assign timer_clear = (state_q == RX_IDLE) || confirm;
   assign par_bad     = cfg_en_q &&
                        (par_bit_q != expected_parity(^shift_q, cfg_odd_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RX_IDLE;
         idx_q      <= '0;
         shift_q    <= '0;
         par_bit_q  <= 1'b0;
         cfg_en_q   <= 1'b0;
         cfg_odd_q  <= 1'b0;
         data_out   <= '0;
         push       <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         push       <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               if (tick && !line) state_q <= RX_START;
            end
            RX_START: begin
               if (half_hit) begin
                  if (line) begin
                     state_q <= RX_IDLE;
                  end else begin
                     state_q   <= RX_DATA;
                     idx_q     <= '0;
                     cfg_en_q  <= par_en_eff;
                     cfg_odd_q <= par_odd;
                  end
               end
            end
            RX_DATA: begin
               if (full_hit) begin
                  shift_q <= {line, shift_q[DATA_W-1:1]};
                  if (idx_q == LAST_IDX) begin
                     state_q <= cfg_en_q ? RX_PAR : RX_STOP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            RX_PAR: begin
               if (full_hit) begin
                  par_bit_q <= line;
                  state_q   <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (full_hit) begin
                  state_q <= RX_IDLE;
                  if (!line) begin
                     frame_err <= 1'b1;
                  end else if (par_bad) begin
                     parity_err <= 1'b1;
                  end else begin
                     push     <= 1'b1;
                     data_out <= shift_q;
                  end
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
`timescale 1ns/1ps
module serial_rx_core #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rx_in,
   input  logic              par_en,
   input  logic              par_odd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_push,
   output logic              rx_frame_err,
   output logic              rx_parity_err
);

   logic line_s;
   logic half_hit;
   logic full_hit;
   logic timer_clear;

   serial_rx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rx_in),
      .d_sync  (line_s)
   );

   serial_rx_timer #(
      .OVS (OVS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .clear    (timer_clear),
      .half_hit (half_hit),
      .full_hit (full_hit)
   );

   serial_rx_fsm #(
      .DATA_W      (DATA_W),
      .PAR_SUPPORT (PAR_SUPPORT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick16),
      .line        (line_s),
      .half_hit    (half_hit),
      .full_hit    (full_hit),
      .par_en      (par_en),
      .par_odd     (par_odd),
      .timer_clear (timer_clear),
      .data_out    (rx_data),
      .push        (rx_push),
      .frame_err   (rx_frame_err),
      .parity_err  (rx_parity_err)
   );

endmodule

// File: rtl/serial_rx_chk.sv
`timescale 1ns/1ps
module serial_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_s,
   input logic              push,
   input logic              frame_err,
   input logic              parity_err,
   input logic [DATA_W-1:0] data
);

   // R2
   push_high_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> $past(line_s));

   // R6
   ferr_low_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !$past(line_s));

   // R6
   ferr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !(push || parity_err));

   // R5
   perr_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |-> !push);

   // R7
   push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);

   // R7
   ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R7
   perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |=> !parity_err);

   // R2
   data_only_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data) |-> push);

endmodule

bind serial_rx_core serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_s     (line_s),
   .push       (rx_push),
   .frame_err  (rx_frame_err),
   .parity_err (rx_parity_err),
   .data       (rx_data)
);

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
module serial_rx_core_tb;

   localparam int TDIV = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick16;
   logic       rx_in;
   logic       par_en;
   logic       par_odd;
   logic [7:0] rx_data;
   logic       rx_push;
   logic       rx_frame_err;
   logic       rx_parity_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int         n_push, n_ferr, n_perr, n_wide;
   logic [7:0] first_data, last_data;
   logic       prev_push, prev_ferr, prev_perr;

   always #5 clk = ~clk;

   serial_rx_core u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick16        (tick16),
      .rx_in         (rx_in),
      .par_en        (par_en),
      .par_odd       (par_odd),
      .rx_data       (rx_data),
      .rx_push       (rx_push),
      .rx_frame_err  (rx_frame_err),
      .rx_parity_err (rx_parity_err)
   );

   initial begin
      tick16 = 1'b0;
      forever begin
         repeat (TDIV - 1) @(negedge clk);
         tick16 = 1'b1;
         @(negedge clk);
         tick16 = 1'b0;
      end
   end

   initial begin
      n_push = 0; n_ferr = 0; n_perr = 0; n_wide = 0;
      first_data = '0; last_data = '0;
      prev_push = 0; prev_ferr = 0; prev_perr = 0;
      forever begin
         @(negedge clk);
         if (rx_push) begin
            if (n_push == 0) first_data = rx_data;
            last_data = rx_data;
            n_push++;
         end
         if (rx_frame_err)  n_ferr++;
         if (rx_parity_err) n_perr++;
         if ((rx_push && prev_push) || (rx_frame_err && prev_ferr) ||
             (rx_parity_err && prev_perr)) n_wide++;
         prev_push = rx_push;
         prev_ferr = rx_frame_err;
         prev_perr = rx_parity_err;
      end
   end

   function automatic logic exp_par(input logic [7:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * TDIV) @(negedge clk);
   endtask

   task automatic drive(input logic b, input int ticks);
      rx_in = b;
      wait_ticks(ticks);
   endtask

   task automatic send(input logic [7:0] d, input logic pen, input logic podd,
                       input logic flip, input logic stop_v, input int stop_ticks);
      par_en  = pen;
      par_odd = podd;
      drive(1'b0, 16);
      for (int i = 0; i < 8; i++) drive(d[i], 16);
      if (pen) drive(exp_par(d, podd) ^ flip, 16);
      drive(stop_v, stop_ticks);
      rx_in = 1'b1;
   endtask

   task automatic clear_mon();
      n_push = 0; n_ferr = 0; n_perr = 0; n_wide = 0;
   endtask

   task automatic expect_result(input string req, input int e_push, input logic [7:0] e_data,
                                input int e_ferr, input int e_perr);
      wait_ticks(10);
      chk({req, " push count"}, n_push, e_push);
      if (e_push > 0) chk({req, " data"}, int'(last_data), int'(e_data));
      chk({req, " frame_err count"}, n_ferr, e_ferr);
      chk({req, " parity_err count"}, n_perr, e_perr);
      chk({"R7 single-cycle strobe in ", req}, n_wide, 0);
      clear_mon();
   endtask

   initial begin
      rst_n = 1'b0; rx_in = 1'b0; par_en = 1'b0; par_odd = 1'b0;
      repeat (6) @(negedge clk);
      chk("R1 reset push", int'(rx_push), 0);
      chk("R1 reset frame_err", int'(rx_frame_err), 0);
      chk("R1 reset parity_err", int'(rx_parity_err), 0);
      chk("R1 reset data", int'(rx_data), 0);
      rx_in = 1'b1;
      rst_n = 1'b1;
      clear_mon();
      wait_ticks(40);
      expect_result("R1 idle line", 0, 8'h00, 0, 0);

      // R2 parity disabled frames
      send(8'hA5, 0, 0, 0, 1, 16); expect_result("R2 A5", 1, 8'hA5, 0, 0);
      send(8'h01, 0, 0, 0, 1, 16); expect_result("R2 LSB first 01", 1, 8'h01, 0, 0);
      send(8'h00, 0, 0, 0, 1, 16); expect_result("R2 00", 1, 8'h00, 0, 0);
      send(8'hFF, 0, 0, 0, 1, 16); expect_result("R2 FF", 1, 8'hFF, 0, 0);

      // R3 glitches, then a good frame
      drive(1'b0, 5); rx_in = 1'b1; wait_ticks(20);
      expect_result("R3 glitch 5", 0, 8'h00, 0, 0);
      drive(1'b0, 7); rx_in = 1'b1; wait_ticks(20);
      expect_result("R3 glitch 7", 0, 8'h00, 0, 0);
      send(8'h5A, 0, 0, 0, 1, 16); expect_result("R3 frame after glitch", 1, 8'h5A, 0, 0);

      // R4 parity match
      send(8'h3C, 1, 0, 0, 1, 16); expect_result("R4 even 3C", 1, 8'h3C, 0, 0);
      send(8'h07, 1, 0, 0, 1, 16); expect_result("R4 even 07", 1, 8'h07, 0, 0);
      send(8'h81, 1, 1, 0, 1, 16); expect_result("R4 odd 81", 1, 8'h81, 0, 0);
      send(8'h0B, 1, 1, 0, 1, 16); expect_result("R4 odd 0B", 1, 8'h0B, 0, 0);

      // R5 parity mismatch
      send(8'h3C, 1, 0, 1, 1, 16); expect_result("R5 even bad", 0, 8'h00, 0, 1);
      send(8'h81, 1, 1, 1, 1, 16); expect_result("R5 odd bad", 0, 8'h00, 0, 1);

      // R6 low stop, with and without bad parity
      send(8'hC3, 0, 0, 0, 0, 12); expect_result("R6 low stop", 0, 8'h00, 1, 0);
      send(8'hC3, 1, 0, 1, 0, 12); expect_result("R6 low stop bad parity", 0, 8'h00, 1, 0);

      // R8 start bit cutting the stop bit short
      send(8'h96, 0, 0, 0, 1, 12);
      send(8'h69, 0, 0, 0, 1, 16);
      wait_ticks(10);
      chk("R8 back-to-back first data", int'(first_data), 8'h96);
      expect_result("R8 back-to-back", 2, 8'h69, 0, 0);

      // Random frames
      void'($urandom(32'd1234));
      for (int k = 0; k < 40; k++) begin
         logic [7:0] d;
         logic pen, podd, flip, stop_v;
         d      = 8'($urandom);
         pen    = 1'($urandom);
         podd   = 1'($urandom);
         flip   = pen && ($urandom_range(0, 5) == 0);
         stop_v = ($urandom_range(0, 7) != 0);
         send(d, pen, podd, flip, stop_v, stop_v ? 16 : 12);
         if (!stop_v)   expect_result("R6 random", 0, 8'h00, 1, 0);
         else if (flip) expect_result("R5 random", 0, 8'h00, 0, 1);
         else if (pen)  expect_result("R4 random", 1, d, 0, 0);
         else           expect_result("R2 random", 1, d, 0, 0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule